// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Edge Interrupts

This block gives software control of eight general-purpose pins through a small byte-wide register interface. Each pin can drive a level or listen. Its tri-state style enable comes from a direction register. Every pin is sampled through a two-stage synchronizer. The synchronized level can always be read back, so a pin being driven reads back its driven value.

A rising edge on any synchronized pin latches a sticky status bit. Software clears a status bit by writing a one to it. A mask register selects which latched bits may raise the single interrupt line. A global enable bit in the mode register gates that line as a whole.

A strap input decides how far configuration survives a platform reset. With the strap low, the platform reset clears the direction and mode settings. With the strap high, only the power-on reset clears them.

Top module: `gpio8_port`

## Requirements
- R1: Register 0 is the direction register: bit i = 1 asserts `pin_oe[i]`. Register 1 is the output register, and it drives `pin_out` bit for bit. Both read back what was written.
- R2: Register 2 returns each pin's level as sampled through two clock stages, whatever the direction setting. Writes to it have no effect.
- R3: With `retain_strap` = 0, a platform reset (`plat_rst_n` low at a clock edge) clears the direction and mode registers. Every register reads 0 after either reset.
- R4: With `retain_strap` = 1, a platform reset leaves the direction and mode registers unchanged but still clears the output, mask and status registers. A power-on reset (`por_n` low) clears everything.
- R5: A rising edge on a synchronized pin sets that pin's bit in status register 4, whether or not the pin is masked.
- R6: Writing register 4 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R7: Register 3 is the mask. `irq` is high exactly when some status bit and its mask bit are both 1 and the global enable is set.
- R8: Bit 0 of register 5 is the global interrupt enable. While it is 0, `irq` stays low.
- R9: When a pin's rising edge and a write-1-to-clear of the same bit reach the same clock edge, the bit ends up set.
- R10: Register 5 bits 7..1 read 0 and ignore writes. Addresses 6 and 7 read 0. `rdata` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| plat_rst_n | input | 1 | Platform reset, active low, sampled synchronously |
| retain_strap | input | 1 | 1 keeps direction and mode through platform reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one clock edge per write |
| rd_en | input | 1 | Read strobe, enables `rdata` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Levels to drive on the pins |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can act in the same clock edge: a pin's edge detector setting a status bit, and a software write-1-to-clear of that same bit. The bench provokes the clash by timing the clear write to the exact edge at which the synchronized rise is latched. That edge is the third one after the pin changes. In the same write it also clears a second bit that has no new event. The result is judged by reading the status register afterwards. The contested bit must still be 1 and the uncontested bit must be 0.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_DIR  = 3'd0,
      RA_OUT  = 3'd1,
      RA_IN   = 3'd2,
      RA_MASK = 3'd3,
      RA_STAT = 3'd4,
      RA_MODE = 3'd5
   } reg_addr_e;

   typedef struct packed {
      logic dir;
      logic out;
      logic mask;
      logic stat;
      logic mode;
   } wr_sel_t;

   localparam int unsigned MODE_EN_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2) $error("gpio_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("gpio_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (clr) stage_q[s] <= '0;
               else     stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (clr) stage_q[s] <= '0;
               else     stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int unsigned PIN_COUNT = 8,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                    clk,
   input  logic                    cfg_clr,
   input  logic                    gen_clr,
   input  gpio8_pkg::wr_sel_t      wr_sel,
   input  logic [DATA_W-1:0]       wdata,
   output logic [PIN_COUNT-1:0]    dir_q,
   output logic [PIN_COUNT-1:0]    out_q,
   output logic [PIN_COUNT-1:0]    mask_q,
   output logic                    irq_en_q
);
   initial begin
      if (PIN_COUNT > DATA_W) $error("gpio_regs: PIN_COUNT exceeds DATA_W");
   end

   genvar p;
   generate
      for (p = 0; p < PIN_COUNT; p++) begin : g_pin
         // configuration domain: strap-selected reset
         always_ff @(posedge clk) begin
            if (cfg_clr)          dir_q[p] <= 1'b0;
            else if (wr_sel.dir)  dir_q[p] <= wdata[p];
         end
         // general domain: any reset
         always_ff @(posedge clk) begin
            if (gen_clr)          out_q[p] <= 1'b0;
            else if (wr_sel.out)  out_q[p] <= wdata[p];
         end
         always_ff @(posedge clk) begin
            if (gen_clr)          mask_q[p] <= 1'b0;
            else if (wr_sel.mask) mask_q[p] <= wdata[p];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (cfg_clr)          irq_en_q <= 1'b0;
      else if (wr_sel.mode) irq_en_q <= wdata[gpio8_pkg::MODE_EN_BIT];
   end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
   parameter int unsigned PIN_COUNT = 8,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 gen_clr,
   input  logic [PIN_COUNT-1:0] lvl,
   input  logic                 stat_wr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [PIN_COUNT-1:0] mask,
   input  logic                 irq_en,
   output logic [PIN_COUNT-1:0] rise,
   output logic [PIN_COUNT-1:0] status_q,
   output logic                 irq
);
   logic [PIN_COUNT-1:0] lvl_d;
   logic [PIN_COUNT-1:0] clr_vec;

   assign clr_vec = stat_wr ? wdata[PIN_COUNT-1:0] : '0;
   assign rise    = lvl & ~lvl_d;

   always_ff @(posedge clk) begin
      if (gen_clr) lvl_d <= '0;
      else         lvl_d <= lvl;
   end

   genvar p;
   generate
      for (p = 0; p < PIN_COUNT; p++) begin : g_stat
         // a new edge takes precedence over a same-cycle clear
         always_ff @(posedge clk) begin
            if (gen_clr)         status_q[p] <= 1'b0;
            else if (rise[p])    status_q[p] <= 1'b1;
            else if (clr_vec[p]) status_q[p] <= 1'b0;
         end
      end
   endgenerate

   assign irq = irq_en & (|(status_q & mask));
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port #(
   parameter int unsigned PIN_COUNT   = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              plat_rst_n,
   input  logic              retain_strap,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic              irq
);
   import gpio8_pkg::*;

   localparam int unsigned PAD_W = DATA_W - PIN_COUNT;

   initial begin
      if (PIN_COUNT != 8)          $error("gpio8_port: PIN_COUNT must be 8");
      if (DATA_W < PIN_COUNT)      $error("gpio8_port: DATA_W too narrow");
      if (ADDR_W < REG_AW)         $error("gpio8_port: ADDR_W too narrow");
      if (SYNC_STAGES < 2)         $error("gpio8_port: need two sync stages");
   end

   logic cfg_clr, gen_clr;
   assign gen_clr = ~por_n | ~plat_rst_n;
   assign cfg_clr = ~por_n | (~plat_rst_n & ~retain_strap);

   logic [REG_AW-1:0] reg_idx;
   logic              in_range;
   generate
      if (ADDR_W > REG_AW) begin : g_wide
         assign in_range = (addr[ADDR_W-1:REG_AW] == '0);
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate
   assign reg_idx = addr[REG_AW-1:0];

   wr_sel_t wr_sel;
   always_comb begin
      wr_sel      = '0;
      if (wr_en && in_range) begin
         unique case (reg_idx)
            RA_DIR:  wr_sel.dir  = 1'b1;
            RA_OUT:  wr_sel.out  = 1'b1;
            RA_MASK: wr_sel.mask = 1'b1;
            RA_STAT: wr_sel.stat = 1'b1;
            RA_MODE: wr_sel.mode = 1'b1;
            default: ;
         endcase
      end
   end

   logic [PIN_COUNT-1:0] sync_lvl;
   logic [PIN_COUNT-1:0] dir_q, out_q, mask_q, status_q, rise_evt;
   logic                 irq_en_q;

   gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .clr (gen_clr),
      .d   (pin_in),
      .q   (sync_lvl)
   );

   gpio_regs #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) i_regs (
      .clk      (clk),
      .cfg_clr  (cfg_clr),
      .gen_clr  (gen_clr),
      .wr_sel   (wr_sel),
      .wdata    (wdata),
      .dir_q    (dir_q),
      .out_q    (out_q),
      .mask_q   (mask_q),
      .irq_en_q (irq_en_q)
   );

   gpio_irq #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) i_irq (
      .clk      (clk),
      .gen_clr  (gen_clr),
      .lvl      (sync_lvl),
      .stat_wr  (wr_sel.stat),
      .wdata    (wdata),
      .mask     (mask_q),
      .irq_en   (irq_en_q),
      .rise     (rise_evt),
      .status_q (status_q),
      .irq      (irq)
   );

   function automatic logic [DATA_W-1:0] widen(input logic [PIN_COUNT-1:0] v);
      return DATA_W'(v);
   endfunction

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (in_range) begin
         case (reg_idx)
            RA_DIR:  rd_mux = widen(dir_q);
            RA_OUT:  rd_mux = widen(out_q);
            RA_IN:   rd_mux = widen(sync_lvl);
            RA_MASK: rd_mux = widen(mask_q);
            RA_STAT: rd_mux = widen(status_q);
            RA_MODE: rd_mux[MODE_EN_BIT] = irq_en_q;
            default: rd_mux = '0;
         endcase
      end
   end

   assign rdata   = rd_en ? rd_mux : '0;
   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   logic unused_pad;
   generate
      if (PAD_W > 0) begin : g_pad
         assign unused_pad = |wdata[DATA_W-1:PIN_COUNT];
      end else begin : g_nopad
         assign unused_pad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk #(
   parameter int unsigned PIN_COUNT = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 3
) (
   input logic                 clk,
   input logic                 por_n,
   input logic                 plat_rst_n,
   input logic                 retain_strap,
   input logic [ADDR_W-1:0]    addr,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [DATA_W-1:0]    wdata,
   input logic [DATA_W-1:0]    rdata,
   input logic [PIN_COUNT-1:0] pin_oe,
   input logic                 irq,
   input logic                 irq_en_q,
   input logic [PIN_COUNT-1:0] status_q,
   input logic [PIN_COUNT-1:0] rise_evt
);
   logic any_rst;
   assign any_rst = ~por_n | ~plat_rst_n;

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (any_rst)
      irq |-> irq_en_q);

   // R5
   rise_sets_status_chk: assert property (@(posedge clk) disable iff (any_rst)
      (rise_evt != '0) |=> ((status_q & $past(rise_evt)) == $past(rise_evt)));

   // R6
   zero_write_keeps_chk: assert property (@(posedge clk) disable iff (any_rst)
      (wr_en && addr == ADDR_W'(4)) |=>
      ((status_q & ($past(status_q) & ~$past(wdata[PIN_COUNT-1:0])))
        == ($past(status_q) & ~$past(wdata[PIN_COUNT-1:0]))));

   // R4
   retain_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
      (retain_strap && !plat_rst_n && !wr_en) |=> $stable(pin_oe));

   // R10
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rd_en |-> (rdata == '0));

   // R10
   mode_reserved_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rd_en && addr == ADDR_W'(5)) |-> (rdata[DATA_W-1:1] == '0));
endmodule

bind gpio8_port gpio8_port_chk #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk          (clk),
   .por_n        (por_n),
   .plat_rst_n   (plat_rst_n),
   .retain_strap (retain_strap),
   .addr         (addr),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .wdata        (wdata),
   .rdata        (rdata),
   .pin_oe       (pin_oe),
   .irq          (irq),
   .irq_en_q     (irq_en_q),
   .status_q     (status_q),
   .rise_evt     (rise_evt)
);

// File: tb/test_gpio8_port.sv
`timescale 1ns/1ps
module test_gpio8_port;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, plat_rst_n = 1'b0, retain_strap = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
   logic       irq;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   gpio8_port i_gpio8_port (
      .clk(clk), .por_n(por_n), .plat_rst_n(plat_rst_n), .retain_strap(retain_strap),
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      por_n = 1'b0; plat_rst_n = 1'b0; idle(3);
      por_n = 1'b1; plat_rst_n = 1'b1; idle(1);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v); check("R3 reset value", v, 8'h00);
      end
      check("R3 reset oe", pin_oe, 8'h00);
      check("R3 reset irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_dir_out;
      logic [7:0] v;
      wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
      check("R1 pin_oe", pin_oe, 8'hA5);
      check("R1 pin_out", pin_out, 8'h3C);
      rd(3'd0, v); check("R1 dir readback", v, 8'hA5);
      rd(3'd1, v); check("R1 out readback", v, 8'h3C);
   endtask

   task automatic t_input;
      logic [7:0] v;
      @(negedge clk); pin_in = 8'h5A; idle(3);
      rd(3'd2, v); check("R2 input level", v, 8'h5A);
      wr(3'd2, 8'hFF);
      rd(3'd2, v); check("R2 input write ignored", v, 8'h5A);
      @(negedge clk); pin_in = 8'h00; idle(3);
      wr(3'd4, 8'hFF);
   endtask

   task automatic t_irq;
      logic [7:0] v;
      wr(3'd3, 8'h00);
      @(negedge clk); pin_in = 8'h04; idle(4);
      rd(3'd4, v); check("R5 unmasked edge sets status", v, 8'h04);
      wr(3'd5, 8'h01);
      check("R7 masked pin no irq", {7'd0, irq}, 8'h00);
      wr(3'd5, 8'h00); wr(3'd3, 8'h04);
      check("R8 enable off no irq", {7'd0, irq}, 8'h00);
      wr(3'd5, 8'h01);
      check("R7 irq asserted", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h00);
      rd(3'd4, v); check("R6 write zero keeps", v, 8'h04);
      wr(3'd4, 8'h04);
      rd(3'd4, v); check("R6 write one clears", v, 8'h00);
      check("R7 irq drops", {7'd0, irq}, 8'h00);
      @(negedge clk); pin_in = 8'h00; idle(3);
   endtask

   task automatic t_collision;
      logic [7:0] v;
      @(negedge clk); pin_in = 8'h03; idle(4);
      @(negedge clk); pin_in = 8'h02; idle(4);
      rd(3'd4, v); check("R9 setup status", v, 8'h03);
      @(negedge clk); pin_in = 8'h03;
      @(negedge clk);
      @(negedge clk); addr = 3'd4; wdata = 8'h03; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      rd(3'd4, v); check("R9 set wins over clear", v, 8'h01);
      @(negedge clk); pin_in = 8'h00; idle(3);
      wr(3'd4, 8'hFF);
   endtask

   task automatic t_reserved;
      logic [7:0] v;
      wr(3'd5, 8'hFF);
      rd(3'd5, v); check("R10 mode reserved bits", v, 8'h01);
      rd(3'd6, v); check("R10 unused address 6", v, 8'h00);
      rd(3'd7, v); check("R10 unused address 7", v, 8'h00);
      @(negedge clk); addr = 3'd0; #1 check("R10 no rd_en", rdata, 8'h00);
   endtask

   task automatic t_retain;
      logic [7:0] v;
      retain_strap = 1'b1;
      wr(3'd0, 8'h0F); wr(3'd5, 8'h01); wr(3'd1, 8'hF0); wr(3'd3, 8'h33);
      @(negedge clk); plat_rst_n = 1'b0; idle(2); plat_rst_n = 1'b1;
      rd(3'd0, v); check("R4 dir kept", v, 8'h0F);
      rd(3'd5, v); check("R4 mode kept", v, 8'h01);
      rd(3'd1, v); check("R4 out cleared", v, 8'h00);
      rd(3'd3, v); check("R4 mask cleared", v, 8'h00);
      retain_strap = 1'b0;
      @(negedge clk); plat_rst_n = 1'b0; idle(2); plat_rst_n = 1'b1;
      rd(3'd0, v); check("R3 dir cleared", v, 8'h00);
      rd(3'd5, v); check("R3 mode cleared", v, 8'h00);
      retain_strap = 1'b1;
      wr(3'd0, 8'h81); wr(3'd5, 8'h01);
      @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1;
      rd(3'd0, v); check("R4 por clears dir", v, 8'h00);
      rd(3'd5, v); check("R4 por clears mode", v, 8'h00);
      retain_strap = 1'b0;
   endtask

   initial begin
      t_reset();
      t_dir_out();
      t_input();
      t_irq();
      t_collision();
      t_reserved();
      t_retain();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule